// File: doc/BRIEF.md
# Bundle Issue Stage with Register Scoreboard

This block is the in-order issue point for a machine that fetches fixed-size instruction bundles. A bundle carries three instruction slots, and the encoding promises that the slots do not depend on one another, so the stage builds no comparators between slots. The template is decoded upstream into a per-slot "used" mask and per-slot register fields. The stage presents one bundle at a time on a valid/ready handshake and raises a strobe for each slot in the cycle that slot issues.

Results from variable-latency operations, such as loads that can miss, are tracked in a scoreboard with one pending bit per architectural register. An outstanding miss does not stall issue by itself. Issue waits only when a later instruction names a pending register as a source, and it resumes when a completion port reports that register.

A slot that follows a variable-latency writer in the same bundle is held for one cycle. The scoreboard then orders any read-after-write between them, so a simultaneous two-register swap inside one bundle is not possible.

Top module: `bundle_issue_sb`

## Requirements
- R1: After reset no register is pending, no slot has issued from the current bundle, `issue_o` is 0 while `bnd_valid` is low, and `bnd_ready` is 1.
- R2: Slots of one bundle whose sources are not pending all issue in the same cycle, even when one slot reads a register that another slot writes with a fixed-latency operation.
- R3: When a slot issues with `slot_var` set and a nonzero destination, that register is pending from the next cycle on. A later slot that reads it as source A or B does not issue until a completion names it.
- R4: A completion on `wb_vld`/`wb_reg` takes effect in its own cycle for the issue check. A reader waiting on that register issues in the completion cycle, and the bit is clear afterwards.
- R5: If a completion and a new variable-latency issue name the same register in one cycle, that register stays pending.
- R6: Slots are considered in order 0, 1, 2. Slots ahead of the first blocked slot issue, and the blocked slot and all later slots wait. `bnd_ready` stays low until every used slot has issued, and no slot issues twice from one bundle.
- R7: A used slot that follows a slot issuing with `slot_var` set and a nonzero destination waits at least until the next cycle, and then issues only if its sources are not pending.
- R8: Register 0 never becomes pending, and reading it never stalls.
- R9: With `bnd_valid` low no slot issues, and the progress within the current bundle is unchanged.
- R10: A slot whose `slot_used` bit is 0 never issues and never holds the bundle. A bundle with no used slots is accepted at once.
- R11: A pending register stalls only its readers. A bundle that reads only non-pending registers issues while other loads are still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bnd_valid | input | 1 | A bundle is presented. The bundle stays stable until accepted |
| bnd_ready | output | 1 | Every used slot of the presented bundle has issued or issues this cycle |
| slot_used | input | NS | Slot s holds a real instruction (bit s) |
| slot_src_a | input | NS*RW | First source register of each slot (slot s at bits s*RW upward) |
| slot_src_b | input | NS*RW | Second source register of each slot |
| slot_dst | input | NS*RW | Destination register of each slot |
| slot_var | input | NS | Slot s produces its result with variable latency |
| wb_vld | input | NWB | Completion port w reports a finished variable-latency result |
| wb_reg | input | NWB*RW | Register number for each completion port |
| issue_o | output | NS | Slot s issues in this cycle |

## Verification
`issue_o` and `bnd_ready` are combinational in the current cycle's inputs, the registered pending bits and the registered per-slot progress. They are therefore due in the same cycle as the stimulus and are sampled on the falling edge, after inputs change just past the rising edge. A pending bit set by an issue acts on the check one cycle later, and a completion acts on the check in its own cycle. The bench's reference model moves its pending and progress state only at the rising edge, in the same order. Directed cases place completions in, before and after the waiting cycles, and seeded random bundles over a small register range add frequent collisions.

// File: rtl/bis_pkg.sv
package bis_pkg;
  parameter int NUM_SLOTS   = 3;
  parameter int NUM_REGS    = 64;
  parameter int NUM_WB      = 2;
  parameter int SLOT_BITS   = 41;
  parameter int BUNDLE_BITS = 128;
  // Bits left over for the template field once all slots are packed.
  localparam int TMPL_BITS  = BUNDLE_BITS - NUM_SLOTS * SLOT_BITS;
  localparam int REG_IDX_W  = $clog2(NUM_REGS);
endpackage

// File: rtl/bis_pending.sv
// Scoreboard: one pending bit per architectural register.
module bis_pending #(
  parameter int NR  = 64,
  parameter int NS  = 3,
  parameter int NWB = 2,
  localparam int RW = $clog2(NR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NS-1:0]     set_vld,
  input  logic [NS*RW-1:0]  set_reg,
  input  logic [NWB-1:0]    wb_vld,
  input  logic [NWB*RW-1:0] wb_reg,
  output logic [NR-1:0]     pend_q,
  output logic [NR-1:0]     clr_vec
);
  logic [NR-1:0] set_vec;
  logic [NR-1:0] pend_d;
  logic          pend_en;

  always_comb begin
    clr_vec = '0;
    for (int w = 0; w < NWB; w++) begin
      if (wb_vld[w]) clr_vec[wb_reg[w*RW +: RW]] = 1'b1;
    end
  end

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < NS; s++) begin
      if (set_vld[s]) set_vec[set_reg[s*RW +: RW]] = 1'b1;
    end
  end

  // A new set wins over a completion naming the same register.
  always_comb begin
    pend_d    = (pend_q & ~clr_vec) | set_vec;
    pend_d[0] = 1'b0;
    pend_en   = (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/bis_src_check.sv
// Source hazard probe for one slot.
module bis_src_check #(
  parameter int NR  = 64,
  localparam int RW = $clog2(NR)
) (
  input  logic [NR-1:0] pend_eff,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  output logic          busy
);
  always_comb busy = pend_eff[src_a] | pend_eff[src_b];
endmodule

// File: rtl/bis_issue_ctrl.sv
// In-order slot issue chain and per-bundle progress mask.
module bis_issue_ctrl #(
  parameter int NS  = 3,
  parameter int RW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bnd_valid,
  input  logic [NS-1:0]    slot_used,
  input  logic [NS-1:0]    slot_var,
  input  logic [NS*RW-1:0] slot_dst,
  input  logic [NS-1:0]    busy,
  output logic [NS-1:0]    issue,
  output logic             bnd_ready,
  output logic [NS-1:0]    set_vld
);
  logic [NS-1:0] done_q;
  logic [NS-1:0] done_d;
  logic          done_en;
  logic [NS-1:0] live;
  logic [NS-1:0] ok;
  logic [NS:0]   hold;

  always_comb begin
    hold[0] = 1'b0;
    for (int s = 0; s < NS; s++) begin
      live[s]   = slot_used[s] & ~done_q[s];
      ok[s]     = live[s] & ~busy[s] & ~hold[s];
      // Later slots wait behind a blocked slot or a variable-latency writer.
      hold[s+1] = hold[s] | (live[s] & busy[s])
                | (ok[s] & slot_var[s] & (slot_dst[s*RW +: RW] != '0));
    end
    bnd_ready = ((live & ~ok) == '0);
    issue     = ok & {NS{bnd_valid}};
    set_vld   = issue & slot_var;
    for (int s = 0; s < NS; s++) begin
      if (slot_dst[s*RW +: RW] == '0) set_vld[s] = 1'b0;
    end
  end

  always_comb begin
    done_en = bnd_valid;
    done_d  = bnd_ready ? '0 : (done_q | issue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= '0;
    else if (done_en) done_q <= done_d;
  end
endmodule

// File: rtl/bundle_issue_sb.sv
module bundle_issue_sb #(
  parameter int NS  = bis_pkg::NUM_SLOTS,
  parameter int NR  = bis_pkg::NUM_REGS,
  parameter int NWB = bis_pkg::NUM_WB,
  localparam int RW = $clog2(NR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_valid,
  output logic              bnd_ready,
  input  logic [NS-1:0]     slot_used,
  input  logic [NS*RW-1:0]  slot_src_a,
  input  logic [NS*RW-1:0]  slot_src_b,
  input  logic [NS*RW-1:0]  slot_dst,
  input  logic [NS-1:0]     slot_var,
  input  logic [NWB-1:0]    wb_vld,
  input  logic [NWB*RW-1:0] wb_reg,
  output logic [NS-1:0]     issue_o
);
  logic [NR-1:0] pend_q;
  logic [NR-1:0] clr_vec;
  logic [NR-1:0] pend_eff;
  logic [NS-1:0] busy;
  logic [NS-1:0] set_vld;

  bis_pending #(.NR(NR), .NS(NS), .NWB(NWB)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_vld(set_vld), .set_reg(slot_dst),
    .wb_vld(wb_vld), .wb_reg(wb_reg),
    .pend_q(pend_q), .clr_vec(clr_vec)
  );

  // Completions are visible to the issue check in their own cycle.
  always_comb pend_eff = pend_q & ~clr_vec;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    bis_src_check #(.NR(NR)) u_chk (
      .pend_eff(pend_eff),
      .src_a(slot_src_a[s*RW +: RW]),
      .src_b(slot_src_b[s*RW +: RW]),
      .busy(busy[s])
    );
  end

  bis_issue_ctrl #(.NS(NS), .RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bnd_valid(bnd_valid), .slot_used(slot_used),
    .slot_var(slot_var), .slot_dst(slot_dst),
    .busy(busy), .issue(issue_o),
    .bnd_ready(bnd_ready), .set_vld(set_vld)
  );
endmodule

module bis_chk #(
  parameter int NS = 3,
  parameter int NR = 64,
  parameter int RW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bnd_valid,
  input logic             bnd_ready,
  input logic [NS-1:0]    slot_used,
  input logic [NS-1:0]    slot_var,
  input logic [NS*RW-1:0] slot_dst,
  input logic [NS-1:0]    issue_o,
  input logic [NR-1:0]    pend
);
  // R9
  issue_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o != '0) |-> bnd_valid);

  // R10
  unused_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o & ~slot_used) == '0);

  // R8
  reg_zero_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0]);

  for (genvar s = 0; s < NS; s++) begin : g_a
    // R3
    var_issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o[s] && slot_var[s] && (slot_dst[s*RW +: RW] != '0))
      |=> pend[$past(slot_dst[s*RW +: RW])]);

    // R6
    no_double_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_valid && !bnd_ready && issue_o[s]) |=> !issue_o[s]);
  end
endmodule

bind bundle_issue_sb bis_chk #(.NS(NS), .NR(NR), .RW(RW)) u_bis_chk (
  .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
  .slot_used(slot_used), .slot_var(slot_var), .slot_dst(slot_dst),
  .issue_o(issue_o), .pend(pend_q)
);

// File: tb/sim_bundle_issue_sb.sv
module sim_bundle_issue_sb;
  localparam int NS = 3, NR = 64, NWB = 2, RW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              b_valid;
  logic [NS-1:0]     b_used, b_var;
  logic [RW-1:0]     b_sa [NS];
  logic [RW-1:0]     b_sb [NS];
  logic [RW-1:0]     b_dst[NS];
  logic [NWB-1:0]    w_vld;
  logic [RW-1:0]     w_reg[NWB];
  logic [NS*RW-1:0]  sa_f, sb_f, dst_f;
  logic [NWB*RW-1:0] wr_f;
  logic              bnd_ready;
  logic [NS-1:0]     issue_o;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      sa_f[s*RW +: RW]  = b_sa[s];
      sb_f[s*RW +: RW]  = b_sb[s];
      dst_f[s*RW +: RW] = b_dst[s];
    end
    for (int w = 0; w < NWB; w++) wr_f[w*RW +: RW] = w_reg[w];
  end

  bundle_issue_sb u0 (
    .clk(clk), .rst_n(rst_n), .bnd_valid(b_valid), .bnd_ready(bnd_ready),
    .slot_used(b_used), .slot_src_a(sa_f), .slot_src_b(sb_f),
    .slot_dst(dst_f), .slot_var(b_var), .wb_vld(w_vld), .wb_reg(wr_f),
    .issue_o(issue_o)
  );

  int checks = 0, failures = 0;
  logic [NR-1:0] m_pend;
  logic [NS-1:0] m_done;
  logic [NS-1:0] e_issue;
  logic          e_ready;
  logic          accepted;
  bit            finished = 0;

  // Reference model built from R2..R11.
  task automatic model_eval(output logic [NS-1:0] ei, output logic er,
                            output logic [NS-1:0] okv);
    logic [NR-1:0] clr, eff;
    logic hold, live, busy;
    clr = '0;
    for (int w = 0; w < NWB; w++) if (w_vld[w]) clr[w_reg[w]] = 1'b1;
    eff = m_pend & ~clr;
    hold = 0; er = 1; okv = '0;
    for (int s = 0; s < NS; s++) begin
      live = b_used[s] && !m_done[s];
      busy = eff[b_sa[s]] || eff[b_sb[s]];
      okv[s] = live && !busy && !hold;
      if (live && !okv[s]) er = 0;
      if (live && busy) hold = 1;
      if (okv[s] && b_var[s] && b_dst[s] != 0) hold = 1;
    end
    ei = b_valid ? okv : '0;
  endtask

  task automatic model_update(input logic [NS-1:0] ei, input logic er);
    logic [NR-1:0] clr, setv;
    clr = '0; setv = '0;
    for (int w = 0; w < NWB; w++) if (w_vld[w]) clr[w_reg[w]] = 1'b1;
    for (int s = 0; s < NS; s++)
      if (ei[s] && b_var[s] && b_dst[s] != 0) setv[b_dst[s]] = 1'b1;
    m_pend = (m_pend & ~clr) | setv;
    m_pend[0] = 1'b0;
    if (b_valid) m_done = er ? '0 : (m_done | ei);
  endtask

  // One cycle: compare at the falling edge, advance the model at the rising edge.
  task automatic cyc(input string tag);
    logic [NS-1:0] okv;
    @(negedge clk);
    model_eval(e_issue, e_ready, okv);
    checks++;
    if (issue_o !== e_issue || bnd_ready !== e_ready) begin
      failures++;
      $display("FAIL %s issue=%b exp=%b ready=%b exp=%b", tag,
               issue_o, e_issue, bnd_ready, e_ready);
    end
    accepted = b_valid && e_ready;
    @(posedge clk);
    model_update(e_issue, e_ready);
    #1;
  endtask

  task automatic clr_bundle();
    b_used = '0; b_var = '0;
    for (int s = 0; s < NS; s++) begin b_sa[s] = 0; b_sb[s] = 0; b_dst[s] = 0; end
  endtask

  task automatic slot(input int s, input int a, input int b, input int d, input bit v);
    b_used[s] = 1'b1; b_sa[s] = RW'(a); b_sb[s] = RW'(b); b_dst[s] = RW'(d); b_var[s] = v;
  endtask

  task automatic wb(input int w, input int r);
    w_vld[w] = 1'b1; w_reg[w] = RW'(r);
  endtask

  task automatic wb_off();
    w_vld = '0; w_reg[0] = 0; w_reg[1] = 0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    if (!finished) $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_pend = '0; m_done = '0;
    b_valid = 0; clr_bundle(); wb_off();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    cyc("R1");

    // R2: fixed-latency writer and readers in one bundle issue together
    b_valid = 1; clr_bundle();
    slot(0, 1, 2, 5, 0); slot(1, 5, 3, 6, 0); slot(2, 5, 6, 8, 0);
    cyc("R2");

    // R3: load to r7, then a reader of r7 stalls
    clr_bundle(); slot(0, 1, 0, 7, 1); cyc("R3");
    clr_bundle(); slot(0, 7, 0, 9, 0);
    repeat (3) cyc("R3");
    // R11: bundle reading other registers waits behind the held bundle;
    // R4: completion in this cycle releases the reader
    wb(0, 7); cyc("R4"); wb_off();
    // R11: new load r20 outstanding, an independent bundle still issues
    clr_bundle(); slot(0, 1, 1, 20, 1); cyc("R11");
    clr_bundle(); slot(0, 3, 4, 2, 0); slot(1, 5, 6, 3, 0); cyc("R11");

    // R6: middle slot blocked on r9
    clr_bundle(); slot(0, 0, 0, 9, 1); cyc("R6");
    clr_bundle(); slot(0, 1, 1, 2, 0); slot(1, 9, 2, 3, 0); slot(2, 4, 4, 5, 0);
    cyc("R6"); cyc("R6");
    wb(1, 9); cyc("R6"); wb_off();

    // R7: slot after a load in the same bundle waits; reader of the load waits longer
    clr_bundle(); slot(0, 1, 1, 10, 1); slot(1, 11, 0, 12, 0); slot(2, 10, 0, 13, 0);
    cyc("R7"); cyc("R7"); cyc("R7");
    wb(0, 10); cyc("R7"); wb_off();

    // R5: r12 pending, re-issued load of r12 in its completion cycle
    clr_bundle(); slot(0, 0, 0, 12, 1); cyc("R5");
    clr_bundle(); slot(0, 1, 1, 12, 1); wb(0, 12); cyc("R5"); wb_off();
    clr_bundle(); slot(0, 12, 0, 14, 0); cyc("R5"); cyc("R5");
    wb(1, 12); cyc("R5"); wb_off();

    // R8: load to r0 never marks it
    clr_bundle(); slot(0, 0, 0, 0, 1); slot(1, 0, 0, 3, 0); cyc("R8");
    clr_bundle(); slot(0, 0, 0, 4, 0); cyc("R8");

    // R10: empty bundle and a hole in the middle
    clr_bundle(); cyc("R10");
    clr_bundle(); slot(0, 1, 1, 2, 0); slot(2, 3, 3, 4, 0); cyc("R10");

    // R9: no valid, stalled bundle keeps its progress
    clr_bundle(); slot(0, 0, 0, 15, 1); cyc("R9");
    clr_bundle(); slot(0, 1, 1, 2, 0); slot(1, 15, 0, 3, 0); cyc("R9");
    b_valid = 0; cyc("R9"); wb(0, 15); cyc("R9"); wb_off();
    b_valid = 1; cyc("R9");
    wb(0, 20); cyc("R9"); wb_off();

    // Random traffic: R2 R3 R4 R5 R6 R7 R11
    accepted = 1;
    for (int i = 0; i < 3000; i++) begin
      if (accepted || !b_valid) begin
        clr_bundle();
        b_valid = ($urandom % 100) < 85;
        for (int s = 0; s < NS; s++) begin
          if ($urandom % 4 != 0)
            slot(s, $urandom % 12, $urandom % 12, $urandom % 12, ($urandom % 10) < 3);
        end
      end
      wb_off();
      for (int w = 0; w < NWB; w++) if ($urandom % 10 < 4) wb(w, $urandom % 12);
      cyc("R6 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule